// File: doc/BRIEF.md
# Key-Guarded System Configuration Registers

This block is the register bank that keeps a chip's global setup words. Two of its registers are guarded: the device-setup word, which routes shared pins to on-chip functions and carries a software reset bit, and the clock-divider word. A guarded register accepts a write only when the bus write just before it put the unlock key into the key register. Each key arms exactly one guarded write. A guarded write that lacks a fresh key leaves the register as it was. Software therefore reads the word, changes the bits it needs, writes the key and then writes the word back.

The bank also holds a read-only identity word whose revision field comes from a parameter. When a committed write clears the software reset bit after it had been set, the block sends a one-cycle reset request to the reset controller. The pin multiplexers and the reset controller are not part of this block. They take the configuration words and the request directly from its outputs.

Top module: `syscfg_keyed_regs`

## Requirements
- R1: Writing the full word 0x000000AA to the key register at word address 0 arms the unlock. From the next cycle, reading address 0 returns 1 while the unlock is armed and 0 while it is not.
- R2: A write to the device-setup word (address 1) or the clock-divider word (address 2) that directly follows an arming write stores the written data. The new value appears on the matching output and on a read of that address in the cycle after the write.
- R3: A write to address 1 or 2 while the unlock is not armed leaves the register and its output unchanged.
- R4: Any bus write disarms the unlock, except a key write of 0x000000AA. This includes a committed guarded write, a key-register write of any other value, a write to address 3, and a write to an unmapped address. Each guarded write therefore needs its own key write.
- R5: Cycles with no bus write leave the armed state unchanged.
- R6: After reset, the device-setup word equals parameter DEVCFG_RST, the clock-divider word equals CLKDIV_RST, the unlock is disarmed, and the reset request is low.
- R7: Bit 31 of the device-setup word is the software reset bit and reads back as last written. The reset request is high for exactly the one cycle after a committed write that changes bit 31 from 1 to 0. Setting the bit, or writing it again with its value unchanged, gives no request.
- R8: Address 3 is read-only. It returns the REVISION parameter in bits 31:24 and zeros elsewhere, and writes to it have no effect on any register.
- R9: Bits 0, 1, 2 and 3 of the device-setup word route the shared pins to the keypad, disk, audio and SPI functions. The whole word is driven on devcfg_o. Reads of word addresses 4 and above return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | AW (4) | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| devcfg_o | output | 32 | Device-setup word, pin routing in bits 3:0 |
| clkdiv_o | output | 32 | Clock-divider word |
| rst_req_o | output | 1 | One-cycle software reset request |

## Verification
A wrong armed flag shows up at the ports in the cycle after the next guarded write. That write either changes devcfg_o or clkdiv_o when it should not, or fails to change them when it should. The key-register readback shows the same flag one cycle after any write. A broken edge detector on the reset bit shows as a missing, extra or two-cycle pulse on rst_req_o in the cycle right after the committing write. Random mixes of key, guarded, stray and idle cycles are compared against a bench model after every cycle, so a fault is caught within one cycle of the operation that exposes it.

// File: rtl/syscfg_pkg.sv
package syscfg_pkg;

    localparam int DW = 32;

    localparam logic [DW-1:0] UNLOCK_KEY = 32'h0000_00AA;

    localparam int SWRST_BIT = 31;
    localparam int ROUTE_KEYPAD = 0;
    localparam int ROUTE_DISK   = 1;
    localparam int ROUTE_AUDIO  = 2;
    localparam int ROUTE_SPI    = 3;

    localparam int REV_LSB = 24;
    localparam int REV_W   = 8;

    localparam int NPROT = 2;

    typedef enum logic [2:0] {
        SEL_KEY    = 3'd0,
        SEL_DEVCFG = 3'd1,
        SEL_CLKDIV = 3'd2,
        SEL_INFO   = 3'd3,
        SEL_NONE   = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic          vld;
        reg_sel_e      sel;
        logic [DW-1:0] data;
    } bus_wr_t;

    function automatic reg_sel_e decode_addr(input int unsigned idx);
        case (idx)
            0: decode_addr = SEL_KEY;
            1: decode_addr = SEL_DEVCFG;
            2: decode_addr = SEL_CLKDIV;
            3: decode_addr = SEL_INFO;
            default: decode_addr = SEL_NONE;
        endcase
    endfunction

    function automatic reg_sel_e prot_sel(input int g);
        prot_sel = (g == 0) ? SEL_DEVCFG : SEL_CLKDIV;
    endfunction

endpackage

// File: rtl/syscfg_unlock.sv
module syscfg_unlock
    import syscfg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bus_wr_t wr,
    output logic    armed_o
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
        end else if (wr.vld) begin
            armed_q <= (wr.sel == SEL_KEY) && (wr.data == UNLOCK_KEY);
        end
    end

    assign armed_o = armed_q;

    // R1: a correct key write arms the unlock
    p_key_arms_r1: assert property (@(posedge clk) disable iff (rst)
        (wr.vld && wr.sel == SEL_KEY && wr.data == UNLOCK_KEY) |=> armed_o);

    // R4: any other write leaves the unlock disarmed
    p_other_write_disarms_r4: assert property (@(posedge clk) disable iff (rst)
        (wr.vld && !(wr.sel == SEL_KEY && wr.data == UNLOCK_KEY)) |=> !armed_o);

    // R5: idle cycles keep the armed state
    p_idle_keeps_r5: assert property (@(posedge clk) disable iff (rst)
        !wr.vld |=> $stable(armed_o));

endmodule

// File: rtl/syscfg_prot_reg.sv
module syscfg_prot_reg
    import syscfg_pkg::*;
#(
    parameter logic [DW-1:0] RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          commit,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] q
);
    logic [DW-1:0] q_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= RST_VAL;
        end else if (commit) begin
            q_r <= d;
        end
    end

    assign q = q_r;

    // R3: without a commit the register holds its value
    p_hold_unless_commit_r3: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(q));

    // R2: a commit loads the data
    p_commit_loads_r2: assert property (@(posedge clk) disable iff (rst)
        commit |=> (q == $past(d)));

endmodule

// File: rtl/syscfg_swrst.sv
module syscfg_swrst
    import syscfg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic commit,
    input  logic bit_now,
    input  logic bit_next,
    output logic req_o
);
    logic req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
        end else begin
            req_q <= commit && bit_now && !bit_next;
        end
    end

    assign req_o = req_q;

    // R7: a request never lasts more than one cycle
    p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        req_o |=> !req_o);

endmodule

// File: rtl/syscfg_keyed_regs.sv
module syscfg_keyed_regs
    import syscfg_pkg::*;
#(
    parameter int              AW         = 4,
    parameter logic [DW-1:0]   DEVCFG_RST = 32'h0000_0005,
    parameter logic [DW-1:0]   CLKDIV_RST = 32'h0000_0010,
    parameter logic [REV_W-1:0] REVISION  = 8'h02
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic [DW-1:0] devcfg_o,
    output logic [DW-1:0] clkdiv_o,
    output logic          rst_req_o
);
    localparam logic [DW-1:0] INFO_WORD = DW'(REVISION) << REV_LSB;

    bus_wr_t       wr;
    reg_sel_e      rd_sel;
    logic          armed;
    logic [DW-1:0] prot_q      [NPROT];
    logic [NPROT-1:0] prot_commit;

    assign wr.vld  = bus_we;
    assign wr.sel  = decode_addr(int'(unsigned'(bus_addr)));
    assign wr.data = bus_wdata;
    assign rd_sel  = decode_addr(int'(unsigned'(bus_addr)));

    syscfg_unlock u_unlock (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .armed_o (armed)
    );

    for (genvar g = 0; g < NPROT; g++) begin : g_prot
        localparam logic [DW-1:0] RV = (g == 0) ? DEVCFG_RST : CLKDIV_RST;
        assign prot_commit[g] = wr.vld && armed && (wr.sel == prot_sel(g));
        syscfg_prot_reg #(.RST_VAL(RV)) u_reg (
            .clk    (clk),
            .rst    (rst),
            .commit (prot_commit[g]),
            .d      (wr.data),
            .q      (prot_q[g])
        );
    end

    syscfg_swrst u_swrst (
        .clk      (clk),
        .rst      (rst),
        .commit   (prot_commit[0]),
        .bit_now  (prot_q[0][SWRST_BIT]),
        .bit_next (wr.data[SWRST_BIT]),
        .req_o    (rst_req_o)
    );

    assign devcfg_o = prot_q[0];
    assign clkdiv_o = prot_q[1];

    always_comb begin
        case (rd_sel)
            SEL_KEY:    bus_rdata = {{(DW-1){1'b0}}, armed};
            SEL_DEVCFG: bus_rdata = prot_q[0];
            SEL_CLKDIV: bus_rdata = prot_q[1];
            SEL_INFO:   bus_rdata = INFO_WORD;
            default:    bus_rdata = '0;
        endcase
    end

    // R4: a guarded commit requires the armed state
    p_commit_needs_key_r4: assert property (@(posedge clk) disable iff (rst)
        (|prot_commit) |-> armed);

    // R7: a reset request follows a 1-to-0 change of the reset bit
    p_req_on_fall_r7: assert property (@(posedge clk) disable iff (rst)
        rst_req_o |-> ($past(devcfg_o[SWRST_BIT]) && !devcfg_o[SWRST_BIT]));

    // R8: the identity word never changes
    p_info_const_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_sel == SEL_INFO) |-> (bus_rdata == INFO_WORD));

endmodule

// File: tb/syscfg_keyed_regs_test.sv
`timescale 1ns/1ps
module syscfg_keyed_regs_test;
    localparam logic [31:0] DEV_RST = 32'h0000_0005;
    localparam logic [31:0] CLK_RST = 32'h0000_0010;
    localparam logic [7:0]  REV     = 8'h02;
    localparam logic [31:0] KEY     = 32'h0000_00AA;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, devcfg_o, clkdiv_o;
    logic        rst_req_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic        m_armed;
    logic [31:0] m_dev, m_div;
    logic        m_req;

    always #2.5 clk = ~clk;

    syscfg_keyed_regs uut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .devcfg_o(devcfg_o),
        .clkdiv_o(clkdiv_o), .rst_req_o(rst_req_o)
    );

    function automatic logic [31:0] exp_read(input logic [3:0] a);
        case (a)
            4'd0: exp_read = {31'b0, m_armed};
            4'd1: exp_read = m_dev;
            4'd2: exp_read = m_div;
            4'd3: exp_read = {REV, 24'b0};
            default: exp_read = 32'b0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " devcfg"}, devcfg_o, m_dev);
        chk({tag, " clkdiv"}, clkdiv_o, m_div);
        chk({tag, " reset request"}, {31'b0, rst_req_o}, {31'b0, m_req});
        for (int a = 0; a < 6; a++) begin
            bus_addr = 4'(a);
            #0.1;
            chk({tag, " readback"}, bus_rdata, exp_read(4'(a)));
        end
    endtask

    // one bus cycle, inputs change at the falling edge
    task automatic cyc(input logic we, input logic [3:0] a, input logic [31:0] d, input string tag);
        bus_we = we; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        m_req = 1'b0;
        if (we) begin
            if (a == 4'd0) begin
                m_armed = (d == KEY);
            end else if ((a == 4'd1 || a == 4'd2) && m_armed) begin
                if (a == 4'd1) begin
                    m_req = m_dev[31] && !d[31];
                    m_dev = d;
                end else begin
                    m_div = d;
                end
                m_armed = 1'b0;
            end else begin
                m_armed = 1'b0;
            end
        end
        @(negedge clk);
        bus_we = 1'b0;
        check_all(tag);
    endtask

    initial begin
        m_armed = 0; m_dev = DEV_RST; m_div = CLK_RST; m_req = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_all("R6 reset state, R8 info, R9 unmapped");

        // R1, R2: key then guarded write
        cyc(1, 0, KEY, "R1 arm");
        cyc(1, 1, 32'h8000_000A, "R2 devcfg write, R7 no pulse on set, R9 routing");
        cyc(1, 0, KEY, "R1 arm");
        cyc(1, 1, 32'h0000_0003, "R7 pulse on clear");
        cyc(0, 0, 0, "R7 pulse ends");
        // R3: no key
        cyc(1, 2, 32'h1234_5678, "R3 ignored without key");
        // R5: idle keeps arming
        cyc(1, 0, KEY, "R1 arm");
        cyc(0, 0, 0, "R5 idle");
        cyc(0, 3, 0, "R5 idle");
        cyc(1, 2, 32'h0000_0042, "R5 write after idle");
        // R4: one key, one write
        cyc(1, 2, 32'h0000_0099, "R4 second write ignored");
        cyc(1, 0, KEY, "R1 arm");
        cyc(1, 0, 32'h0000_01AA, "R4 wrong key disarms");
        cyc(1, 1, 32'hFFFF_FFFF, "R4 write after wrong key ignored");
        cyc(1, 0, KEY, "R1 arm");
        cyc(1, 3, 32'hFFFF_FFFF, "R8 info write ignored");
        cyc(1, 1, 32'hFFFF_FFFF, "R4 write after stray write ignored");
        cyc(1, 0, KEY, "R1 arm");
        cyc(1, 9, 32'h0, "R4 unmapped write disarms");
        cyc(1, 2, 32'h0, "R4 write after unmapped ignored");
        cyc(1, 0, KEY, "R1 arm");
        cyc(1, 1, 32'h8000_0000, "R7 set bit");
        cyc(1, 0, KEY, "R1 arm");
        cyc(1, 1, 32'h8000_0001, "R7 keep bit no pulse");

        // random mix
        void'($urandom(32'd1234));
        for (int i = 0; i < 600; i++) begin
            int k;
            logic [31:0] d;
            k = int'($urandom_range(0, 9));
            d = $urandom();
            if (k < 3)       cyc(1, 0, KEY, "R1 random arm");
            else if (k < 6)  cyc(1, 4'($urandom_range(1, 2)), d, "R2 R3 random guarded write");
            else if (k == 6) cyc(1, 0, ($urandom_range(0, 1) == 0) ? (d | 32'h100) : KEY, "R4 random key write");
            else if (k == 7) cyc(1, 4'($urandom_range(3, 15)), d, "R4 random stray write");
            else             cyc(0, 4'($urandom_range(0, 15)), d, "R5 random idle");
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule